// File: doc/BRIEF.md
# NAND Asynchronous Read Strobe Generator

This block performs single-byte reads from an asynchronous NAND device. Each read request first waits for the device ready/busy line, which is active low. A busy timeout limits this wait. The block then holds the strobe high for a programmable number of address-setup cycles. Next it drives the active-low read strobe low for a setup count and high for a hold count. All counts are measured in controller clock cycles.

The returned byte is not captured at the strobe's own rising edge. It is captured on a delayed copy of that edge, so the block can read devices whose data stays valid after the strobe goes high (extended data out timing). The delay is programmed in eighth-period taps. A half-period option makes each tap one sixteenth of a clock period.

A request is a valid/ready handshake that carries no payload; the timing configuration inputs are sampled when the request is accepted. The captured byte is returned on a valid/ready response channel. The response is held stable for as long as the consumer keeps `rsp_ready` low, and a new request is not accepted until the response has been taken. If the busy timeout expires, the block returns no response. It sets a sticky timeout flag and goes back to idle.

Top module: `nand_rd_strobe`

## Requirements
- R1: After reset, `nand_re_n` is 1, `req_ready` is 1, `rsp_valid` is 0 and `busy_timeout` is 0.
- R2: For each read, `nand_re_n` stays low for exactly S clock cycles in a single pulse. S is `cfg_data_setup`, or 1 when that input is 0.
- R3: From the strobe rising edge, `nand_re_n` stays high for max(H, M) cycles before `rsp_valid` is asserted. H is `cfg_data_hold`, or 1 when that input is 0. M is the capture edge index from R5/R6.
- R4: Number the clock edges after the accepting edge 1, 2, 3 and so on. The strobe falls at edge 1+L+A, where L is the number of waiting cycles that saw `nand_rb_n` low and A is `cfg_addr_setup`. A may be 0.
- R5: When `cfg_rd_delay` is 0, the byte returned is the value of `nand_din` at the clock edge where the strobe rises (M = 0).
- R6: When `cfg_rd_delay` is D > 0, the byte is captured M = ceil(D / T) clock edges after the strobe rising edge. T = 8 normally and T = 16 when `cfg_half_period` is 1.
- R7: Each waiting cycle samples `nand_rb_n`. If it reads 1, the read proceeds. The timeout fires at the waiting cycle whose index equals the busy limit (`cfg_busy_limit`, or 1 when that input is 0) if `nand_rb_n` is still 0 there. A timeout produces no response and leaves the block idle.
- R8: `busy_timeout` stays at 1 from a timeout until reset. Reads that follow a timeout still complete normally.
- R9: Changing any `cfg_*` input after the request has been accepted has no effect on the read in progress.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` does not change. `req_ready` is 1 only while no read or response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Block idle, request accepted when both high |
| cfg_addr_setup | input | CNT_W | Address-setup cycles before the strobe falls |
| cfg_data_setup | input | CNT_W | Strobe-low cycles |
| cfg_data_hold | input | CNT_W | Strobe-high cycles |
| cfg_rd_delay | input | TAP_W | Capture delay in taps |
| cfg_half_period | input | 1 | Tap is 1/16 clock period instead of 1/8 |
| cfg_busy_limit | input | TMO_W | Busy wait limit in cycles |
| nand_re_n | output | 1 | Read strobe to the device, active low |
| nand_din | input | DATA_W | Data byte from the device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0), already synchronous |
| rsp_valid | output | 1 | Captured byte available |
| rsp_ready | input | 1 | Consumer takes the byte |
| rsp_data | output | DATA_W | Captured byte |
| busy_timeout | output | 1 | Sticky busy-timeout flag |

## Verification
The bench changes `nand_din` on every clock edge after the strobe rises, so each post-rise edge presents a distinct value. An off-by-one in the tap accumulator or the half-period step therefore returns a neighbouring byte in the very response that is affected. Wrong phase counters show up within one read as a shifted strobe fall, a pulse of the wrong width, or a response that arrives early or late. A wrong busy counter makes the timeout flag rise one cycle away from its limit, or makes the boundary read fail when the device goes ready on the last allowed cycle.

// File: rtl/nand_rs_pkg.sv
package nand_rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ADDR,
    ST_LOW,
    ST_HIGH,
    ST_RESP
  } rs_state_t;
endpackage

// File: rtl/nrs_busy_timer.sv
module nrs_busy_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             rb_n,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] lim_eff;
  logic [TMO_W:0]   cnt_inc;

  assign lim_eff = (limit == '0) ? TMO_W'(1) : limit;
  assign cnt_inc = {1'b0, cnt_q} + (TMO_W+1)'(1);
  assign expired = active && !rb_n && (cnt_inc >= {1'b0, lim_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
    end else if (!rb_n && !expired) begin
      cnt_q <= cnt_inc[TMO_W-1:0];
    end
  end
endmodule

// File: rtl/nrs_tap_capture.sv
module nrs_tap_capture #(
  parameter int DATA_W = 8,
  parameter int TAP_W  = 4,
  parameter int TAPS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise,
  input  logic [TAP_W-1:0]  rd_delay,
  input  logic              half,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] data_q,
  output logic              cap_ok
);
  localparam int ACC_W = $clog2(2*TAPS + (1 << TAP_W)) + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;
  logic             pend_q;
  logic             done_q;
  logic             fire;
  logic             reached;

  assign step    = half ? ACC_W'(2*TAPS) : ACC_W'(TAPS);
  assign reached = acc_q >= ACC_W'(rd_delay);
  assign fire    = (rise && (rd_delay == '0)) || (pend_q && reached);
  assign cap_ok  = done_q || fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (clr) begin
        acc_q  <= '0;
        pend_q <= 1'b0;
        done_q <= 1'b0;
      end else begin
        if (rise) begin
          pend_q <= (rd_delay != '0);
          acc_q  <= step;
        end else if (pend_q) begin
          if (reached) pend_q <= 1'b0;
          else         acc_q  <= acc_q + step;
        end
        if (fire) done_q <= 1'b1;
      end
      if (fire) data_q <= din;
    end
  end
endmodule

// File: rtl/nrs_phase_seq.sv
module nrs_phase_seq
  import nand_rs_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TAP_W = 4,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CNT_W-1:0] cfg_addr_setup,
  input  logic [CNT_W-1:0] cfg_data_setup,
  input  logic [CNT_W-1:0] cfg_data_hold,
  input  logic [TAP_W-1:0] cfg_rd_delay,
  input  logic             cfg_half_period,
  input  logic [TMO_W-1:0] cfg_busy_limit,
  input  logic             rb_n,
  input  logic             busy_expired,
  input  logic             cap_ok,
  input  logic             rsp_ready,
  output logic             rsp_valid,
  output logic             strobe_n,
  output logic             wait_active,
  output logic             rise_pulse,
  output logic             xfer_start,
  output logic [TAP_W-1:0] lat_rd_delay,
  output logic             lat_half,
  output logic [TMO_W-1:0] lat_busy_limit,
  output logic             timeout_flag
);
  rs_state_t        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] as_q, ds_q, dh_q;
  logic [CNT_W-1:0] ds_eff, dh_eff;
  logic [CNT_W:0]   cnt_inc;
  logic             re_n_q, tmo_q, set_tmo;

  assign ds_eff  = (ds_q == '0) ? CNT_W'(1) : ds_q;
  assign dh_eff  = (dh_q == '0) ? CNT_W'(1) : dh_q;
  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

  assign req_ready    = (state_q == ST_IDLE);
  assign rsp_valid    = (state_q == ST_RESP);
  assign wait_active  = (state_q == ST_WAIT);
  assign xfer_start   = req_ready && req_valid;
  assign strobe_n     = re_n_q;
  assign timeout_flag = tmo_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    rise_pulse = 1'b0;
    set_tmo    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
      end
      ST_WAIT: begin
        if (rb_n) begin
          state_d = (as_q == '0) ? ST_LOW : ST_ADDR;
          cnt_d   = '0;
        end else if (busy_expired) begin
          state_d = ST_IDLE;
          set_tmo = 1'b1;
        end
      end
      ST_ADDR: begin
        if (cnt_inc >= {1'b0, as_q}) begin
          state_d = ST_LOW;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
      ST_LOW: begin
        if (cnt_inc >= {1'b0, ds_eff}) begin
          state_d    = ST_HIGH;
          cnt_d      = '0;
          rise_pulse = 1'b1;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
      ST_HIGH: begin
        if ((cnt_inc >= {1'b0, dh_eff}) && cap_ok) begin
          state_d = ST_RESP;
        end else if (cnt_q != '1) begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
      ST_RESP: begin
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      cnt_q          <= '0;
      re_n_q         <= 1'b1;
      tmo_q          <= 1'b0;
      as_q           <= '0;
      ds_q           <= '0;
      dh_q           <= '0;
      lat_rd_delay   <= '0;
      lat_half       <= 1'b0;
      lat_busy_limit <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      re_n_q  <= (state_d != ST_LOW);
      if (set_tmo) tmo_q <= 1'b1;
      if (xfer_start) begin
        as_q           <= cfg_addr_setup;
        ds_q           <= cfg_data_setup;
        dh_q           <= cfg_data_hold;
        lat_rd_delay   <= cfg_rd_delay;
        lat_half       <= cfg_half_period;
        lat_busy_limit <= cfg_busy_limit;
      end
    end
  end
endmodule

// File: rtl/nand_rd_strobe.sv
module nand_rd_strobe #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int TAP_W  = 4,
  parameter int TAPS   = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CNT_W-1:0]  cfg_addr_setup,
  input  logic [CNT_W-1:0]  cfg_data_setup,
  input  logic [CNT_W-1:0]  cfg_data_hold,
  input  logic [TAP_W-1:0]  cfg_rd_delay,
  input  logic              cfg_half_period,
  input  logic [TMO_W-1:0]  cfg_busy_limit,
  output logic              nand_re_n,
  input  logic [DATA_W-1:0] nand_din,
  input  logic              nand_rb_n,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy_timeout
);
  logic             wait_active, busy_expired, cap_ok;
  logic             rise_pulse, xfer_start, lat_half;
  logic [TAP_W-1:0] lat_rd_delay;
  logic [TMO_W-1:0] lat_busy_limit;

  nrs_phase_seq #(.CNT_W(CNT_W), .TAP_W(TAP_W), .TMO_W(TMO_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .cfg_addr_setup (cfg_addr_setup),
    .cfg_data_setup (cfg_data_setup),
    .cfg_data_hold  (cfg_data_hold),
    .cfg_rd_delay   (cfg_rd_delay),
    .cfg_half_period(cfg_half_period),
    .cfg_busy_limit (cfg_busy_limit),
    .rb_n           (nand_rb_n),
    .busy_expired   (busy_expired),
    .cap_ok         (cap_ok),
    .rsp_ready      (rsp_ready),
    .rsp_valid      (rsp_valid),
    .strobe_n       (nand_re_n),
    .wait_active    (wait_active),
    .rise_pulse     (rise_pulse),
    .xfer_start     (xfer_start),
    .lat_rd_delay   (lat_rd_delay),
    .lat_half       (lat_half),
    .lat_busy_limit (lat_busy_limit),
    .timeout_flag   (busy_timeout)
  );

  nrs_busy_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (wait_active),
    .rb_n   (nand_rb_n),
    .limit  (lat_busy_limit),
    .expired(busy_expired)
  );

  nrs_tap_capture #(.DATA_W(DATA_W), .TAP_W(TAP_W), .TAPS(TAPS)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (xfer_start),
    .rise    (rise_pulse),
    .rd_delay(lat_rd_delay),
    .half    (lat_half),
    .din     (nand_din),
    .data_q  (rsp_data),
    .cap_ok  (cap_ok)
  );
endmodule

// File: rtl/nand_rd_strobe_chk.sv
module nand_rd_strobe_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              nand_re_n,
  input logic              busy_timeout
);
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_idle_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_timeout |=> busy_timeout);

  p_tmo_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_timeout) |-> (req_ready && !rsp_valid));

  p_strobe_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || rsp_valid) |-> nand_re_n);
endmodule

bind nand_rd_strobe nand_rd_strobe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .nand_re_n   (nand_re_n),
  .busy_timeout(busy_timeout)
);

// File: tb/nand_rd_strobe_bench.sv
module nand_rd_strobe_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] cfg_addr_setup = '0, cfg_data_setup = '0, cfg_data_hold = '0;
  logic [3:0] cfg_rd_delay = '0;
  logic       cfg_half_period = 1'b0;
  logic [15:0] cfg_busy_limit = '0;
  logic       nand_re_n;
  logic [7:0] nand_din = '0;
  logic       nand_rb_n = 1'b1;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [7:0] rsp_data;
  logic       busy_timeout;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [7:0] din_base = '0;
  int k = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  nand_rd_strobe u_nand_rd_strobe (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_addr_setup(cfg_addr_setup), .cfg_data_setup(cfg_data_setup),
    .cfg_data_hold(cfg_data_hold), .cfg_rd_delay(cfg_rd_delay),
    .cfg_half_period(cfg_half_period), .cfg_busy_limit(cfg_busy_limit),
    .nand_re_n(nand_re_n), .nand_din(nand_din), .nand_rb_n(nand_rb_n),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy_timeout(busy_timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Device model: each edge after the strobe rises presents base + edge index.
  always @(negedge clk) begin
    if (!nand_re_n) k = 0;
    else k = k + 1;
    nand_din = din_base + 8'(k);
  end

  // Monitor: pops the scoreboard when a response handshake is set up.
  always @(negedge clk) begin
    #1;
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R5/R6 unexpected response", int'(rsp_data), -1);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rsp_data == e, "R5/R6 captured byte", int'(rsp_data), int'(e));
      end
    end
  end

  task automatic run_read(input int as, input int ds, input int dh, input int rdn,
                          input int hf, input int lim, input int lowc,
                          input int stall, input logic [7:0] base, input bit exp_tmo);
    int step, m, dse, dhe, lime, exp_high;
    int first_low, lowcnt, highcnt, rsp_idx, tmo_idx;
    logic [7:0] held;
    step = hf ? 16 : 8;
    m    = (rdn == 0) ? 0 : (rdn + step - 1) / step;
    dse  = (ds == 0) ? 1 : ds;
    dhe  = (dh == 0) ? 1 : dh;
    lime = (lim == 0) ? 1 : lim;
    exp_high = (dhe > m) ? dhe : m;
    first_low = 0; lowcnt = 0; highcnt = 0; rsp_idx = 0; tmo_idx = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_addr_setup = 8'(as); cfg_data_setup = 8'(ds); cfg_data_hold = 8'(dh);
    cfg_rd_delay = 4'(rdn); cfg_half_period = hf[0]; cfg_busy_limit = 16'(lim);
    din_base = base;
    nand_rb_n = (lowc == 0);
    req_valid = 1'b1;
    if (!exp_tmo) exp_q.push_back(base + 8'(m));
    @(negedge clk);
    req_valid = 1'b0;
    // R9: disturb configuration after acceptance
    cfg_addr_setup = 8'(as + 5); cfg_data_setup = 8'(ds + 3); cfg_data_hold = 8'(dh + 4);
    cfg_rd_delay = ~4'(rdn); cfg_half_period = ~hf[0]; cfg_busy_limit = 16'(lim + 9);
    for (int i = 1; i < 400; i++) begin
      if (i > 1) @(negedge clk);
      nand_rb_n = (i > lowc);
      if (exp_tmo) begin
        if (busy_timeout) begin tmo_idx = i; break; end
        if (!nand_re_n || rsp_valid) break;
      end else begin
        if (rsp_valid) begin rsp_idx = i; break; end
        if (!nand_re_n) begin
          if (first_low == 0) first_low = i;
          lowcnt++;
        end else if (first_low != 0) begin
          highcnt++;
        end
      end
    end
    nand_rb_n = 1'b1;
    if (exp_tmo) begin
      check(tmo_idx == lime + 1, "R7 timeout cycle", tmo_idx, lime + 1);
      check(req_ready && !rsp_valid, "R7 idle after timeout", int'(req_ready), 1);
      check(exp_q.size() == 0, "R7 no response", exp_q.size(), 0);
    end else begin
      check(first_low == 2 + lowc + as, "R4/R9 strobe fall", first_low, 2 + lowc + as);
      check(lowcnt == dse, "R2/R9 strobe low width", lowcnt, dse);
      check(highcnt == exp_high, "R3/R9 strobe high before response", highcnt, exp_high);
      held = rsp_data;
      for (int j = 0; j < stall; j++) begin
        @(negedge clk);
        check(rsp_valid && rsp_data == held, "R10 response held", int'(rsp_data), int'(held));
        check(!req_ready, "R10 no request while response pending", int'(req_ready), 0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      #2;
      check(exp_q.size() == 0, "R10 response consumed", exp_q.size(), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(nand_re_n == 1'b1, "R1 strobe reset", int'(nand_re_n), 1);
    check(req_ready == 1'b1, "R1 req_ready reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid reset", int'(rsp_valid), 0);
    check(busy_timeout == 1'b0, "R1 timeout reset", int'(busy_timeout), 0);
    rst_n = 1'b1;
    // R5 direct capture, minimal timing, no address setup
    run_read(0, 1, 1, 0, 0, 10, 0, 0, 8'h10, 0);
    // R6 one-edge delay, address setup R4
    run_read(2, 3, 2, 4, 0, 10, 0, 0, 8'h20, 0);
    // R6 delay longer than hold extends the high phase (R3)
    run_read(1, 2, 1, 9, 0, 10, 0, 0, 8'h30, 0);
    // R6 half-period taps halve the edge count
    run_read(1, 2, 1, 9, 1, 10, 0, 0, 8'h40, 0);
    // R2/R3 zero counts treated as one, max delay
    run_read(0, 0, 0, 15, 0, 10, 0, 0, 8'h50, 0);
    // R10 back-pressure on the response
    run_read(3, 4, 3, 8, 0, 10, 0, 3, 8'hF0, 0);
    // R7 boundary: ready on the last allowed waiting cycle
    run_read(1, 2, 2, 0, 0, 4, 3, 0, 8'h60, 0);
    check(busy_timeout == 1'b0, "R7 no timeout at boundary", int'(busy_timeout), 0);
    // R7 timeout
    run_read(1, 2, 2, 0, 0, 4, 4, 0, 8'h70, 1);
    // R8 sticky flag, later read still works
    run_read(0, 2, 2, 16'd3, 1, 0, 0, 1, 8'h80, 0);
    check(busy_timeout == 1'b1, "R8 timeout sticky", int'(busy_timeout), 1);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule